// File: doc/BRIEF.md
# External Memory Bus Strobe Decoder

This block turns each bus cycle issued by a CPU core with a 24-bit address space into the control signals of a narrow external memory bus. The core presents an address, a cycle kind (instruction fetch, data read or data write) and a one-cycle start pulse. The block decides whether the access stays inside the device's on-chip code store or goes out to the pins. For an external access it drives one of three active-low strobes (a general read strobe, a program-store read strobe or a write strobe) for a number of cycles that depends on the addressed 64 KB region. It holds `ready` high in the last cycle of every access.

Static configuration inputs select one of four bus modes. The modes trade upper address pins for general-purpose I/O and decide which read strobe serves which region. A wait-state enable slows down region 01. An active-low remap enable makes data accesses to the top 8 KB of region 00 land in the upper half of the on-chip code store. The two shared pins either carry the two highest external address bits or pass through port-register values. In the split mode, the lower pin is the general read strobe itself.

Top module: `xbus_strobe_dec`

## Requirements
- R1: While `rst_n` is low and after reset is released with no access started, all three strobes are high, `ready` and `onchip_hit` are low, and in mode 00 both `pin_hi` and `pin_lo` read 0.
- R2: An access is accepted at a rising edge where `cyc_start` is high and the block is either idle or in the `ready` cycle of the previous access. Its strobe or on-chip flag appears in the cycle right after that edge. A start seen in a non-final cycle of an access is ignored.
- R3: An external access holds its strobe low for one cycle, or for two cycles when its address lies in region 01 (bits 23:16 equal 0x01) and `cfg_nowait` is 0. `ready` is high only in the last of those cycles.
- R4: A data write (`cyc_kind` = 2'b10) to an external address drives `wr_n` low in every bus mode.
- R5: Fetches (`cyc_kind` = 2'b00) and data reads (2'b01, with 2'b11 treated the same way) to external addresses use `rd_n` in modes 00 and 01, and `prog_rd_n` in mode 10.
- R6: In mode 11, external reads with address bit 23 clear use `rd_n`, and those with bit 23 set use `prog_rd_n`. `pin_lo` then carries the level of `rd_n`.
- R7: In mode 00, `pin_hi` and `pin_lo` show address bits 17 and 16 of the latest accepted external access. In mode 01, `pin_hi` follows `gpio_hi` and `pin_lo` shows bit 16. In mode 10, both pins follow `gpio_hi` and `gpio_lo`. In mode 11, `pin_hi` follows `gpio_hi`.
- R8: Any access to 0xFF0000–0xFF3FFF is on-chip. It raises `onchip_hit` and `ready` together for one cycle, keeps all strobes high, does not wait in any region, and gives `onchip_addr` = address − 0xFF0000.
- R9: With `cfg_remap_n` = 0, a data read or write to 0x00E000–0x00FFFF is on-chip with `onchip_addr` = 0x2000 + (address − 0x00E000). Fetches to that window, and all accesses to it with `cfg_remap_n` = 1, go external.
- R10: At most one strobe is low at any time, and none is low while no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Start request for a bus cycle |
| cyc_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 data read |
| cyc_addr | input | ADDR_W | Byte address of the cycle |
| cfg_mode | input | 2 | Bus mode 00/01/10/11 |
| cfg_nowait | input | 1 | 1 removes the wait state of region 01 |
| cfg_remap_n | input | 1 | 0 enables the data-window remap into on-chip code |
| gpio_hi | input | 1 | Port-register value for the upper shared pin |
| gpio_lo | input | 1 | Port-register value for the lower shared pin |
| rd_n | output | 1 | General read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| prog_rd_n | output | 1 | Program-store read strobe, active low |
| pin_hi | output | 1 | Upper shared pin: address bit 17 or I/O |
| pin_lo | output | 1 | Lower shared pin: address bit 16, I/O or read strobe |
| onchip_hit | output | 1 | Access served by the on-chip code store |
| onchip_addr | output | ONCHIP_AW | Offset into the on-chip code store |
| ready | output | 1 | Last cycle of the current access |

## Verification
The hardest situation to reach from the ports is a start request that coincides with a running access. Depending on the cycle, that request must be dropped (wait cycle) or chained (ready cycle), and the address pins must keep the earlier access's bits until the chained one is taken. The bench holds `cyc_start` high across a slow region-01 access with a different address and kind, then checks that the first strobe is unchanged and that the write strobe follows in the very next cycle. The rest comes from a full sweep over every mode, cycle kind, wait and remap setting and a set of addresses placed at window edges and region boundaries.

// File: rtl/xbd_pkg.sv
package xbd_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RD   = 2'd1,
    SEL_PS   = 2'd2,
    SEL_WR   = 2'd3
  } xbd_sel_e;

  localparam logic [1:0] MODE_WIDE   = 2'b00;
  localparam logic [1:0] MODE_MID    = 2'b01;
  localparam logic [1:0] MODE_NARROW = 2'b10;
  localparam logic [1:0] MODE_SPLIT  = 2'b11;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  function automatic logic f_is_write(input logic [1:0] kind);
    return kind == KIND_WRITE;
  endfunction

  function automatic logic f_is_data(input logic [1:0] kind);
    return kind != KIND_FETCH;
  endfunction

  // read strobe choice: split mode steers by the top address bit
  function automatic xbd_sel_e f_read_sel(input logic [1:0] mode, input logic top_bit);
    xbd_sel_e s;
    case (mode)
      MODE_NARROW: s = SEL_PS;
      MODE_SPLIT:  s = top_bit ? SEL_PS : SEL_RD;
      default:     s = SEL_RD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/xbd_region_decode.sv
module xbd_region_decode
  import xbd_pkg::*;
#(
  parameter int          ADDR_W        = 24,
  parameter int          ONCHIP_AW     = 14,
  parameter logic [7:0]  ONCHIP_REGION = 8'hFF,
  parameter logic [7:0]  SLOW_REGION   = 8'h01
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           kind,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_nowait,
  input  logic                 cfg_remap_n,
  output logic                 is_onchip,
  output logic                 is_slow,
  output xbd_sel_e             sel,
  output logic [ONCHIP_AW-1:0] int_addr
);
  localparam int REG_LO     = ADDR_W - 8;
  localparam int OFS_W      = REG_LO;
  localparam int REMAP_LOG2 = ONCHIP_AW - 1;

  logic [7:0]       region;
  logic [OFS_W-1:0] offset;
  logic             direct_hit;
  logic             window_hit;
  logic             redirect;

  assign region = addr[ADDR_W-1:REG_LO];
  assign offset = addr[REG_LO-1:0];

  // on-chip code occupies the low part of its region
  assign direct_hit = (region == ONCHIP_REGION) &&
                      (offset[OFS_W-1:ONCHIP_AW] == '0);
  // remap window: top slice of region 00 with the same size as half the store
  assign window_hit = (region == 8'h00) && (&offset[OFS_W-1:REMAP_LOG2]);
  assign redirect   = window_hit && f_is_data(kind) && !cfg_remap_n;

  assign is_onchip = direct_hit || redirect;
  assign is_slow   = !is_onchip && (region == SLOW_REGION) && !cfg_nowait;

  always_comb begin
    if (redirect) int_addr = {1'b1, offset[REMAP_LOG2-1:0]};
    else          int_addr = offset[ONCHIP_AW-1:0];
  end

  always_comb begin
    if (is_onchip)            sel = SEL_NONE;
    else if (f_is_write(kind)) sel = SEL_WR;
    else                      sel = f_read_sel(cfg_mode, addr[ADDR_W-1]);
  end

endmodule

// File: rtl/xbd_access_seq.sv
module xbd_access_seq
  import xbd_pkg::*;
#(
  parameter int WAIT_CYC  = 1,
  parameter int ONCHIP_AW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  xbd_sel_e             sel_in,
  input  logic                 slow_in,
  input  logic                 onchip_in,
  input  logic [ONCHIP_AW-1:0] int_addr_in,
  input  logic [1:0]           hi_bits_in,
  output logic                 active,
  output logic                 accept,
  output logic                 ready,
  output xbd_sel_e             sel_q,
  output logic                 onchip_q,
  output logic [ONCHIP_AW-1:0] int_addr_q,
  output logic [1:0]           hi_bits_q
);
  localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

  logic [CNT_W-1:0] wait_left;

  assign ready  = active && (wait_left == '0);
  assign accept = start && (!active || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sel_q      <= SEL_NONE;
      onchip_q   <= 1'b0;
      wait_left  <= '0;
      int_addr_q <= '0;
      hi_bits_q  <= '0;
    end else if (accept) begin
      active     <= 1'b1;
      sel_q      <= sel_in;
      onchip_q   <= onchip_in;
      wait_left  <= slow_in ? CNT_W'(WAIT_CYC) : '0;
      int_addr_q <= int_addr_in;
      if (sel_in != SEL_NONE) hi_bits_q <= hi_bits_in;
    end else if (ready) begin
      active   <= 1'b0;
      sel_q    <= SEL_NONE;
      onchip_q <= 1'b0;
    end else if (active) begin
      wait_left <= wait_left - 1'b1;
    end
  end

endmodule

// File: rtl/xbd_pin_mux.sv
module xbd_pin_mux
  import xbd_pkg::*;
(
  input  logic       active,
  input  xbd_sel_e   sel_q,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] hi_bits_q,
  input  logic       gpio_hi,
  input  logic       gpio_lo,
  output logic       rd_n,
  output logic       wr_n,
  output logic       prog_rd_n,
  output logic       pin_hi,
  output logic       pin_lo
);
  assign rd_n      = !(active && sel_q == SEL_RD);
  assign wr_n      = !(active && sel_q == SEL_WR);
  assign prog_rd_n = !(active && sel_q == SEL_PS);

  assign pin_hi = (cfg_mode == MODE_WIDE) ? hi_bits_q[1] : gpio_hi;

  always_comb begin
    case (cfg_mode)
      MODE_WIDE, MODE_MID: pin_lo = hi_bits_q[0];
      MODE_NARROW:         pin_lo = gpio_lo;
      default:             pin_lo = rd_n;
    endcase
  end

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbd_pkg::*;
#(
  parameter int         ADDR_W        = 24,
  parameter int         ONCHIP_AW     = 14,
  parameter int         WAIT_CYC      = 1,
  parameter logic [7:0] ONCHIP_REGION = 8'hFF,
  parameter logic [7:0] SLOW_REGION   = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_start,
  input  logic [1:0]           cyc_kind,
  input  logic [ADDR_W-1:0]    cyc_addr,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_nowait,
  input  logic                 cfg_remap_n,
  input  logic                 gpio_hi,
  input  logic                 gpio_lo,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 prog_rd_n,
  output logic                 pin_hi,
  output logic                 pin_lo,
  output logic                 onchip_hit,
  output logic [ONCHIP_AW-1:0] onchip_addr,
  output logic                 ready
);
  localparam int REG_LO = ADDR_W - 8;

  // named internal events, also observed by the bound checker
  logic                 dec_onchip;
  logic                 dec_slow;
  xbd_sel_e             dec_sel;
  logic [ONCHIP_AW-1:0] dec_int_addr;
  logic                 acc_active;
  logic                 acc_accept;
  logic                 acc_ready;
  xbd_sel_e             acc_sel;
  logic                 acc_onchip;
  logic [1:0]           acc_hi_bits;

  xbd_region_decode #(
    .ADDR_W(ADDR_W), .ONCHIP_AW(ONCHIP_AW),
    .ONCHIP_REGION(ONCHIP_REGION), .SLOW_REGION(SLOW_REGION)
  ) decode_i (
    .addr(cyc_addr), .kind(cyc_kind), .cfg_mode(cfg_mode),
    .cfg_nowait(cfg_nowait), .cfg_remap_n(cfg_remap_n),
    .is_onchip(dec_onchip), .is_slow(dec_slow), .sel(dec_sel),
    .int_addr(dec_int_addr)
  );

  xbd_access_seq #(.WAIT_CYC(WAIT_CYC), .ONCHIP_AW(ONCHIP_AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(cyc_start),
    .sel_in(dec_sel), .slow_in(dec_slow), .onchip_in(dec_onchip),
    .int_addr_in(dec_int_addr), .hi_bits_in(cyc_addr[REG_LO+1:REG_LO]),
    .active(acc_active), .accept(acc_accept), .ready(acc_ready),
    .sel_q(acc_sel), .onchip_q(acc_onchip), .int_addr_q(onchip_addr),
    .hi_bits_q(acc_hi_bits)
  );

  xbd_pin_mux pins_i (
    .active(acc_active), .sel_q(acc_sel), .cfg_mode(cfg_mode),
    .hi_bits_q(acc_hi_bits), .gpio_hi(gpio_hi), .gpio_lo(gpio_lo),
    .rd_n(rd_n), .wr_n(wr_n), .prog_rd_n(prog_rd_n),
    .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  assign onchip_hit = acc_active && acc_onchip;
  assign ready      = acc_ready;

endmodule

// File: rtl/xbd_checker.sv
module xbd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       accept,
  input logic [1:0] dec_sel,
  input logic [1:0] cfg_mode,
  input logic       rd_n,
  input logic       wr_n,
  input logic       prog_rd_n,
  input logic       pin_hi,
  input logic       pin_lo,
  input logic       gpio_hi,
  input logic       onchip_hit,
  input logic       ready
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (rd_n && wr_n && prog_rd_n && !ready && !onchip_hit));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rd_n, !wr_n, !prog_rd_n}));

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_sel == 2'd3) |=> !wr_n);

  p_onchip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    onchip_hit |-> (ready && rd_n && wr_n && prog_rd_n));

  p_hold_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready) |=> (active && $stable({rd_n, wr_n, prog_rd_n})));

  p_ready_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !accept) |=> !active);

  p_upper_pin_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'b00) |-> (pin_hi == gpio_hi));

  p_split_read_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b11) |-> (pin_lo == rd_n));
endmodule

bind xbus_strobe_dec xbd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .active(acc_active), .accept(acc_accept),
  .dec_sel(dec_sel), .cfg_mode(cfg_mode), .rd_n(rd_n), .wr_n(wr_n),
  .prog_rd_n(prog_rd_n), .pin_hi(pin_hi), .pin_lo(pin_lo),
  .gpio_hi(gpio_hi), .onchip_hit(onchip_hit), .ready(ready)
);

// File: tb/xbus_strobe_dec_tb.sv
module xbus_strobe_dec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start = 1'b0;
  logic [1:0]  cyc_kind = 2'b00;
  logic [23:0] cyc_addr = '0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_nowait = 1'b0;
  logic        cfg_remap_n = 1'b1;
  logic        gpio_hi = 1'b0;
  logic        gpio_lo = 1'b0;
  logic        rd_n, wr_n, prog_rd_n, pin_hi, pin_lo, onchip_hit, ready;
  logic [13:0] onchip_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic last_hi = 1'b0;
  logic last_lo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_strobe_dec dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .cyc_addr(cyc_addr), .cfg_mode(cfg_mode), .cfg_nowait(cfg_nowait),
    .cfg_remap_n(cfg_remap_n), .gpio_hi(gpio_hi), .gpio_lo(gpio_lo),
    .rd_n(rd_n), .wr_n(wr_n), .prog_rd_n(prog_rd_n), .pin_hi(pin_hi),
    .pin_lo(pin_lo), .onchip_hit(onchip_hit), .onchip_addr(onchip_addr),
    .ready(ready)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h (addr %06h mode %0d kind %0d)",
               req, what, got, exp, cyc_addr, cfg_mode, cyc_kind);
    end
  endtask

  // expected strobes as {rd_n, wr_n, prog_rd_n}
  function automatic logic [2:0] model_strobes(input int mode, input int kind, input int a, input bit on);
    if (on) return 3'b111;
    if (kind == 2) return 3'b101;
    if (mode == 2) return 3'b110;
    if (mode == 3) return (a < 'h800000) ? 3'b011 : 3'b110;
    return 3'b011;
  endfunction

  task automatic run_access(input int mode, input int kind, input int a,
                            input bit nw, input bit rm_n, input bit ghi, input bit glo);
    bit direct, redir, on;
    int len, exp_int;
    logic [2:0] es;
    string sreq;
    direct = (a >= 'hFF0000) && (a <= 'hFF3FFF);
    redir  = (a >= 'h00E000) && (a <= 'h00FFFF) && (kind != 0) && !rm_n;
    on     = direct || redir;
    len    = (!on && (a / 'h10000) == 1 && !nw) ? 2 : 1;
    exp_int = direct ? (a - 'hFF0000) : (a - 'hE000 + 'h2000);
    es = model_strobes(mode, kind, a, on);
    sreq = on ? (redir ? "R9" : "R8") : (kind == 2 ? "R4" : (mode == 3 ? "R6" : "R5"));
    if (!on) begin
      last_hi = 1'((a / 'h20000) % 2);
      last_lo = 1'((a / 'h10000) % 2);
    end
    cfg_mode = 2'(mode); cyc_kind = 2'(kind); cyc_addr = 24'(a);
    cfg_nowait = nw; cfg_remap_n = rm_n; gpio_hi = ghi; gpio_lo = glo;
    cyc_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    for (int k = 0; k < len; k++) begin
      check(sreq, "strobes", {rd_n, wr_n, prog_rd_n}, es);
      check("R3", "ready", ready, (k == len - 1));
      check(on ? sreq : "R8", "onchip_hit", onchip_hit, on);
      if (on) check(sreq, "onchip_addr", onchip_addr, exp_int);
      check("R7", "pin_hi", pin_hi, (mode == 0) ? last_hi : ghi);
      check(mode == 3 ? "R6" : "R7", "pin_lo", pin_lo,
            (mode <= 1) ? last_lo : ((mode == 2) ? glo : es[2]));
      @(negedge clk);
    end
    check("R10", "idle strobes", {rd_n, wr_n, prog_rd_n}, 3'b111);
    check("R10", "idle ready", ready, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] addrs [13];
    addrs = '{24'h000000, 24'h00DFFF, 24'h00E000, 24'h00FFFF, 24'h010000,
              24'h01E000, 24'h02FFFF, 24'h7F1234, 24'h80ABCD, 24'hFE0000,
              24'hFF0000, 24'hFF3FFF, 24'hFF4000};
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset strobes", {rd_n, wr_n, prog_rd_n}, 3'b111);
    check("R1", "reset ready", ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle strobes", {rd_n, wr_n, prog_rd_n}, 3'b111);
    check("R1", "idle ready/hit", {ready, onchip_hit}, 2'b00);
    check("R1", "pins after reset", {pin_hi, pin_lo}, 2'b00);

    // sweep: R3..R10
    for (int m = 0; m < 4; m++)
      for (int kd = 0; kd < 3; kd++)
        for (int nw = 0; nw < 2; nw++)
          for (int rm = 0; rm < 2; rm++)
            for (int i = 0; i < 13; i++)
              run_access(m, kd, int'(addrs[i]), nw[0], rm[0],
                         1'(i % 2) ^ nw[0], 1'(i / 2 % 2) ^ rm[0]);

    // R2: a start during the wait cycle is dropped, one in the ready cycle chains
    cfg_mode = 2'b00; cfg_nowait = 1'b0; cfg_remap_n = 1'b1;
    cyc_kind = 2'b01; cyc_addr = 24'h010000; cyc_start = 1'b1;
    @(posedge clk); @(negedge clk);
    cyc_kind = 2'b10; cyc_addr = 24'h020000;
    check("R2", "slow read cycle 1", {rd_n, wr_n, prog_rd_n, ready}, 4'b0110);
    check("R2", "pins kept", {pin_hi, pin_lo}, 2'b01);
    @(negedge clk);
    check("R2", "start ignored while waiting", {rd_n, wr_n, prog_rd_n, ready}, 4'b0111);
    check("R2", "pins still first access", {pin_hi, pin_lo}, 2'b01);
    @(negedge clk);
    cyc_start = 1'b0;
    check("R2", "chained write", {rd_n, wr_n, prog_rd_n, ready}, 4'b1011);
    check("R2", "pins of chained access", {pin_hi, pin_lo}, 2'b10);
    @(negedge clk);
    check("R2", "idle after chain", {rd_n, wr_n, prog_rd_n, ready}, 4'b1110);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule